// File: doc/BRIEF.md
# Levelled Vectored Interrupt Arbiter

The arbiter watches a bank of level-sensitive interrupt request lines, masks them with a per-source enable register, and chooses one pending source. Each source has a stored configuration: a priority level, a target register-set number, a handler address and a non-maskable flag. The chosen source's configuration is checked against the processor's current state. That state is a global interrupt-enable bit, the current interrupt level, the active register set and a bit that permits interrupts into the active register set. If the check passes, the arbiter issues a registered request packet to the processor.

The packet holds its value until the processor pulses an acknowledge. The arbiter then clears the request for one cycle and evaluates again. Software loads the enable register and the per-source entries through simple write ports. Every entry, and the enable register, comes out of reset cleared.

Top module: `irq_level_arbiter`

## Requirements
- R1: A source is pending only when its request line is high and its enable bit is set. Bit n of each vector belongs to source n. A source that is not pending never appears in a request.
- R2: Among pending maskable sources the highest level is selected. On equal levels the lower source number is selected.
- R3: A pending source whose non-maskable flag is set is selected ahead of every maskable source. Among non-maskable sources, level and then lower source number decide.
- R4: A maskable selection produces a request only while the global interrupt-enable input is 1. If the selected source is refused, no request is issued in that cycle.
- R5: A maskable selection produces a request only if its level is strictly greater than `cur_level`.
- R6: While `rsie` is 0, a maskable selection whose register set equals `cur_rset` produces no request.
- R7: A non-maskable selection produces a request regardless of `gie`, `cur_level`, `cur_rset` and `rsie`.
- R8: The request packet (`req_src`, `req_nmi`, `req_level`, `req_rset`, `req_handler`) carries the selected source's number and its stored configuration. Source configuration is 6-bit level, 6-bit register set (0 to 63) and 32-bit handler address.
- R9: A request appears on the clock edge after the inputs that cause it. Its valid bit and fields then stay unchanged while `req_ack` is low, even if the request lines change.
- R10: On the edge after an acknowledged cycle, `req_valid` is 0. On the following edge the arbiter may raise a new request from the inputs of that moment.
- R11: After reset the enable register and all source entries are zero, and no request is raised even with all request lines high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_SRC | Level-sensitive request lines |
| mask_we | input | 1 | Write strobe for the enable register |
| mask_wdata | input | NUM_SRC | New enable register value |
| cfg_we | input | 1 | Write strobe for one source entry |
| cfg_idx | input | IDX_W | Source entry written |
| cfg_nmi | input | 1 | Non-maskable flag to store |
| cfg_level | input | 6 | Level to store |
| cfg_rset | input | 6 | Register set to store |
| cfg_handler | input | 32 | Handler address to store |
| gie | input | 1 | Global interrupt enable |
| cur_level | input | 6 | Current interrupt level |
| cur_rset | input | 6 | Active register set |
| rsie | input | 1 | Permit interrupts into the active register set |
| req_ack | input | 1 | Processor accepts the request |
| req_valid | output | 1 | Request packet valid |
| req_src | output | IDX_W | Selected source number |
| req_nmi | output | 1 | Request is non-maskable |
| req_level | output | 6 | Requested level |
| req_rset | output | 6 | Requested register set |
| req_handler | output | 32 | Requested handler address |

## Verification
A corrupted enable bit or source entry shows at the ports on the next request. The wrong source wins, or a field of the packet differs from what was written. The bench sweeps every request pattern of a small instance, so each stored bit is exercised within a few hundred cycles. A broken gating term shows as a request that appears or vanishes one edge after the processor state is changed. A fault in the output register shows within a cycle as a packet that moves while unacknowledged, or as a missing one-cycle gap after an acknowledge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LEVEL_W   = 6;
  localparam int RSET_W    = 6;
  localparam int HANDLER_W = 32;
  localparam int KEY_W     = LEVEL_W + 1;

  typedef struct packed {
    logic                 nmi;
    logic [LEVEL_W-1:0]   level;
    logic [RSET_W-1:0]    rset;
    logic [HANDLER_W-1:0] handler;
  } src_cfg_t;

  // Ordering key: non-maskable first, then level.
  function automatic logic [KEY_W-1:0] rank_of(src_cfg_t c);
    return {c.nmi, c.level};
  endfunction
endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  src_cfg_t           cfg_wdata,
  output logic [NUM_SRC-1:0] mask_q,
  output src_cfg_t           cfg_tab [NUM_SRC]
);
  logic [NUM_SRC-1:0] mask_n;

  always_comb begin
    mask_n = mask_q;
    if (mask_we) mask_n = mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_n;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
    logic     load;
    src_cfg_t ent_n;
    src_cfg_t ent_q;

    always_comb begin
      load  = cfg_we && (cfg_idx == IDX_W'(g));
      ent_n = ent_q;
      if (load) ent_n = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_n;
    end

    assign cfg_tab[g] = ent_q;
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pending,
  input  src_cfg_t           cfg_tab [NUM_SRC],
  output logic               found,
  output logic [IDX_W-1:0]   win_idx,
  output src_cfg_t           win_cfg
);
  logic [KEY_W-1:0] best_key;

  // Scan from the top so that ">=" hands ties to the lower number.
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_cfg  = '0;
    best_key = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i] && (!found || rank_of(cfg_tab[i]) >= best_key)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_cfg  = cfg_tab[i];
        best_key = rank_of(cfg_tab[i]);
      end
    end
  end
endmodule

// File: rtl/irq_take_gate.sv
module irq_take_gate
  import irq_arb_pkg::*;
(
  input  logic              found,
  input  src_cfg_t          win_cfg,
  input  logic              gie,
  input  logic [LEVEL_W-1:0] cur_level,
  input  logic [RSET_W-1:0] cur_rset,
  input  logic              rsie,
  output logic              take
);
  logic lvl_ok;
  logic rset_ok;

  always_comb begin
    lvl_ok  = win_cfg.level > cur_level;
    rset_ok = rsie || (win_cfg.rset != cur_rset);
    take    = found && (win_cfg.nmi || (gie && lvl_ok && rset_ok));
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_lines,
  input  logic                 mask_we,
  input  logic [NUM_SRC-1:0]   mask_wdata,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic                 cfg_nmi,
  input  logic [LEVEL_W-1:0]   cfg_level,
  input  logic [RSET_W-1:0]    cfg_rset,
  input  logic [HANDLER_W-1:0] cfg_handler,
  input  logic                 gie,
  input  logic [LEVEL_W-1:0]   cur_level,
  input  logic [RSET_W-1:0]    cur_rset,
  input  logic                 rsie,
  input  logic                 req_ack,
  output logic                 req_valid,
  output logic [IDX_W-1:0]     req_src,
  output logic                 req_nmi,
  output logic [LEVEL_W-1:0]   req_level,
  output logic [RSET_W-1:0]    req_rset,
  output logic [HANDLER_W-1:0] req_handler
);
  src_cfg_t           wr_cfg;
  src_cfg_t           cfg_tab [NUM_SRC];
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pending;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  src_cfg_t           win_cfg;
  logic               take;

  assign wr_cfg = '{nmi: cfg_nmi, level: cfg_level, rset: cfg_rset, handler: cfg_handler};

  irq_cfg_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(wr_cfg),
    .mask_q(mask_q), .cfg_tab(cfg_tab)
  );

  assign pending = irq_lines & mask_q;

  irq_prio_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .pending(pending), .cfg_tab(cfg_tab),
    .found(found), .win_idx(win_idx), .win_cfg(win_cfg)
  );

  irq_take_gate u_gate (
    .found(found), .win_cfg(win_cfg),
    .gie(gie), .cur_level(cur_level), .cur_rset(cur_rset), .rsie(rsie),
    .take(take)
  );

  // Output packet register: valid flag plus a load-enabled payload.
  logic             vld_q, vld_n;
  logic             pkt_load;
  src_cfg_t         pkt_q, pkt_n;
  logic [IDX_W-1:0] src_q, src_n;

  always_comb begin
    vld_n    = vld_q;
    pkt_load = 1'b0;
    if (vld_q) begin
      if (req_ack) vld_n = 1'b0;
    end else if (take) begin
      vld_n    = 1'b1;
      pkt_load = 1'b1;
    end
    pkt_n = pkt_load ? win_cfg : pkt_q;
    src_n = pkt_load ? win_idx : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pkt_q <= '0;
      src_q <= '0;
    end else begin
      vld_q <= vld_n;
      pkt_q <= pkt_n;
      src_q <= src_n;
    end
  end

  assign req_valid   = vld_q;
  assign req_src     = src_q;
  assign req_nmi     = pkt_q.nmi;
  assign req_level   = pkt_q.level;
  assign req_rset    = pkt_q.rset;
  assign req_handler = pkt_q.handler;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_src) && $stable(req_handler)
                                 && $stable(req_level) && $stable(req_rset) && $stable(req_nmi)));

  assert_drop_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack) |=> !req_valid);

  assert_src_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> ((($past(pending) >> req_src) & NUM_SRC'(1)) != '0));

  assert_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && !req_nmi) |-> $past(gie));

  assert_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && !req_nmi) |-> (req_level > $past(cur_level)));

  assert_rset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && !req_nmi && !$past(rsie)) |-> (req_rset != $past(cur_rset)));
endmodule

// File: tb/irq_level_arbiter_bench.sv
`timescale 1ns/1ps
module irq_level_arbiter_bench;
  localparam int NS = 8;
  localparam int PW = 1 + 3 + 1 + 6 + 6 + 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] irq_lines;
  logic          mask_we;
  logic [NS-1:0] mask_wdata;
  logic          cfg_we;
  logic [2:0]    cfg_idx;
  logic          cfg_nmi;
  logic [5:0]    cfg_level;
  logic [5:0]    cfg_rset;
  logic [31:0]   cfg_handler;
  logic          gie;
  logic [5:0]    cur_level;
  logic [5:0]    cur_rset;
  logic          rsie;
  logic          req_ack;
  logic          req_valid;
  logic [2:0]    req_src;
  logic          req_nmi;
  logic [5:0]    req_level;
  logic [5:0]    req_rset;
  logic [31:0]   req_handler;

  irq_level_arbiter #(.NUM_SRC(NS)) u_irq_level_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_nmi(cfg_nmi), .cfg_level(cfg_level),
    .cfg_rset(cfg_rset), .cfg_handler(cfg_handler),
    .gie(gie), .cur_level(cur_level), .cur_rset(cur_rset), .rsie(rsie),
    .req_ack(req_ack), .req_valid(req_valid), .req_src(req_src), .req_nmi(req_nmi),
    .req_level(req_level), .req_rset(req_rset), .req_handler(req_handler)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Bench copy of what software wrote.
  logic [NS-1:0] m_en;
  logic          m_nmi [NS];
  int            m_lvl [NS];
  int            m_rs  [NS];

  function automatic logic [31:0] hnd(int i);
    return 32'h0000_8000 + 32'(i * 64);
  endfunction

  function automatic logic [PW-1:0] actual_pkt();
    if (!req_valid) return '0;
    return {req_valid, req_src, req_nmi, req_level, req_rset, req_handler};
  endfunction

  function automatic logic [PW-1:0] expect_pkt(logic [NS-1:0] lines);
    logic [NS-1:0] pend;
    bit            hit;
    int            w;
    int            bk;
    bit            ok;
    pend = lines & m_en;
    hit  = 0;
    w    = 0;
    bk   = 0;
    for (int i = 0; i < NS; i++) begin
      int k;
      k = (m_nmi[i] ? 1000 : 0) + m_lvl[i];
      if (pend[i] && (!hit || k > bk)) begin
        hit = 1; w = i; bk = k;
      end
    end
    if (!hit) return '0;
    ok = m_nmi[w] || (gie && (m_lvl[w] > int'(cur_level)) && (rsie || m_rs[w] != int'(cur_rset)));
    if (!ok) return '0;
    return {1'b1, 3'(w), m_nmi[w], 6'(m_lvl[w]), 6'(m_rs[w]), hnd(w)};
  endfunction

  task automatic check(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_src(int i, bit nmi, int lvl, int rs);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(i); cfg_nmi = nmi;
    cfg_level = 6'(lvl); cfg_rset = 6'(rs); cfg_handler = hnd(i);
    @(negedge clk);
    cfg_we = 1'b0;
    m_nmi[i] = nmi; m_lvl[i] = lvl; m_rs[i] = rs;
  endtask

  task automatic wr_en(logic [NS-1:0] m);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = m;
    @(negedge clk);
    mask_we = 1'b0;
    m_en = m;
  endtask

  // Called at a falling edge with no request outstanding.
  task automatic run_case(string tag, logic [NS-1:0] lines);
    irq_lines = lines;
    @(negedge clk);
    check(tag, actual_pkt(), expect_pkt(lines));
    irq_lines = '0;
    if (req_valid) begin
      req_ack = 1'b1;
      @(negedge clk);
      req_ack = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_lines = '0; mask_we = 1'b0; mask_wdata = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_nmi = 1'b0; cfg_level = '0; cfg_rset = '0;
    cfg_handler = '0; gie = 1'b1; cur_level = '0; cur_rset = '0; rsie = 1'b1;
    req_ack = 1'b0; m_en = '0;
    for (int i = 0; i < NS; i++) begin m_nmi[i] = 0; m_lvl[i] = 0; m_rs[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: cleared after reset, nothing raised with all lines high.
    check("R11 reset valid", {{(PW-1){1'b0}}, req_valid}, '0);
    run_case("R11 all lines after reset", '1);

    for (int i = 0; i < NS; i++) wr_src(i, 0, (i % 7) + 1, i % 4);
    wr_en('1);

    // R8: each source alone carries its own entry.
    for (int i = 0; i < NS; i++) run_case("R8 single source", NS'(1) << i);

    // R2: every pattern, all enabled (sources 0 and 7 tie at level 1).
    for (int p = 1; p < 256; p++) run_case("R2 pattern sweep", NS'(p));

    // R1: partial enable register.
    wr_en(8'hA5);
    for (int p = 0; p < 256; p++) run_case("R1 masked sweep", NS'(p));
    wr_en('1);

    // R5: source 3 has level 4; strict compare.
    for (int c = 0; c < 8; c++) begin
      cur_level = 6'(c);
      run_case("R5 level gate", 8'h08);
    end
    cur_level = '0;

    // R4: global enable off.
    gie = 1'b0;
    run_case("R4 gie off all", '1);
    run_case("R4 gie off one", 8'h10);
    gie = 1'b1;

    // R6: register-set guard (source 5 targets set 1, source 6 set 2).
    rsie = 1'b0;
    for (int r = 0; r < 4; r++) begin
      cur_rset = 6'(r);
      run_case("R6 rset gate", 8'h20);
    end
    cur_rset = 6'd2;
    run_case("R6 winner blocked", '1);
    cur_rset = 6'd3;
    run_case("R6 winner allowed", '1);

    // R3 / R7: non-maskable sources 1 and 4 at equal level, all gating hostile.
    wr_src(1, 1, 2, 1);
    wr_src(4, 1, 2, 0);
    gie = 1'b0; cur_level = 6'd63; cur_rset = 6'd1;
    run_case("R7 nmi bypass", 8'h02);
    run_case("R7 nmi on active set", 8'h12);
    for (int p = 0; p < 256; p++) run_case("R3 nmi sweep", NS'(p));

    // R9 / R10: hold without acknowledge, gap, then re-evaluation.
    gie = 1'b1; cur_level = '0; rsie = 1'b1;
    irq_lines = 8'h01;
    @(negedge clk);
    check("R9 request after one edge", actual_pkt(), {1'b1, 3'd0, 1'b0, 6'd1, 6'd0, hnd(0)});
    irq_lines = 8'h40;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 hold until ack", actual_pkt(), {1'b1, 3'd0, 1'b0, 6'd1, 6'd0, hnd(0)});
    end
    req_ack = 1'b1;
    @(negedge clk);
    req_ack = 1'b0;
    check("R10 gap after ack", {{(PW-1){1'b0}}, req_valid}, '0);
    @(negedge clk);
    check("R10 re-evaluation", actual_pkt(), {1'b1, 3'd6, 1'b0, 6'd7, 6'd2, hnd(6)});
    irq_lines = '0;
    req_ack = 1'b1;
    @(negedge clk);
    req_ack = 1'b0;
    @(negedge clk);
    check("R10 cleared", {{(PW-1){1'b0}}, req_valid}, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule